// File: doc/BRIEF.md
# Stack-Addressed Floating-Point Register File

This block holds the eight working registers of a stack-organised floating-point unit. A 3-bit top pointer rotates over a physical array, and every register name is an offset from it: ST(0) is the register the pointer selects, and ST(i) lies i places further on, wrapping around the array. Each physical entry has a tag bit that marks it as holding a value or as empty. The arithmetic and the instruction decode sit outside the block. They present one operation per clock cycle, together with a stack offset and the data the operation needs.

Each cycle the block can do one of five things. It can push a value, pop the stack, or write a result back to ST(0). It can also write a result back to ST(i), either alone or together with a pop. The write-and-pop case serves add-and-pop operations: the result goes to ST(i), and ST(0) is then released, all in one clock edge. If an operation names an empty register, the block reports a stack underflow. If a push would land on an occupied register, it reports a stack overflow. A faulting operation changes nothing: no data is written, no tag changes and the pointer does not move. The fault pulses a flag, and condition bit C1 is loaded with the direction of the fault. A separate read port returns ST(0) and a chosen ST(n), with their tags, so that the arithmetic unit can fetch its operands. The width of the data is a parameter.

Top module: `fpstk_regfile`

## Requirements
- R1: After a synchronous reset, `top_q` is 0, every tag is empty (both read-port full flags read 0), and `stk_fault` and `cond_c1` are 0.
- R2: The read port addresses physical entry (`top_q` + `rd_idx`) mod 8 for `sti_q` and entry `top_q` for `st0_q`. The data and full flags are registered and appear one cycle after `rd_idx` is sampled. They show the contents as they stood before that same edge's update.
- R3: A push (`op` = 1) whose target is empty decrements `top_q` by 1 mod 8. It writes `push_data` into the new ST(0) and marks it full.
- R4: A push whose target register (ST(0) after the decrement) is full is an overflow. The cycle after it, `stk_fault` is 1 and `cond_c1` is 1, and no state changes.
- R5: A pop (`op` = 2) with ST(0) full marks that entry empty and increments `top_q` by 1 mod 8.
- R6: A write to ST(0) (`op` = 3) stores `wb_data` in ST(0). It references both ST(0) and ST(`idx`), and `idx` = 0 is legal (the source and the destination are then the same register, as when ST(0) is doubled).
- R7: A write to ST(i) (`op` = 4) stores `wb_data` in ST(`idx`). It references both ST(0) and ST(`idx`), and `top_q` is unchanged.
- R8: A write-and-pop (`op` = 5) stores `wb_data` in ST(`idx`) and pops, both on one edge, so the result is found at ST(`idx`-1) afterwards. With `idx` = 1 it is the no-operand add-and-pop form.
- R9: If an operation with `op` from 2 to 5 references an empty register, that is an underflow. The cycle after it, `stk_fault` is 1 and `cond_c1` is 0; no data is written, no pop happens and `top_q` is unchanged.
- R10: `stk_fault` is high only in the cycle that follows a faulting operation. `cond_c1` holds its value until the next fault.
- R11: `top_q` wraps modulo 8: a push at 0 gives 7, and a pop at 7 gives 0.
- R12: The `op` codes 0, 6 and 7 do nothing: tags, data and `top_q` keep their values and no fault is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 3 | Operation: 0 none, 1 push, 2 pop, 3 write ST(0), 4 write ST(i), 5 write ST(i) and pop |
| idx | input | 3 | Stack offset i for operations 3 to 5 |
| push_data | input | DATA_W | Value for a push |
| wb_data | input | DATA_W | Result for a write-back |
| rd_idx | input | 3 | Stack offset of the second read port |
| st0_q | output | DATA_W | Registered contents of ST(0) |
| sti_q | output | DATA_W | Registered contents of ST(rd_idx) |
| st0_full | output | 1 | Registered tag of ST(0) |
| sti_full | output | 1 | Registered tag of ST(rd_idx) |
| top_q | output | 3 | Top-of-stack pointer |
| stk_fault | output | 1 | Stack fault pulse |
| cond_c1 | output | 1 | Condition bit C1: 1 after an overflow, 0 after an underflow |

## Verification
The operation's effects are due one edge after it is sampled: `top_q`, `stk_fault` and `cond_c1` already show the result, and so does data written to the array. The read port lags by one edge, and what it returns is the contents as they stood before the operation sampled on that same edge. The bench therefore drives each operation on a falling edge, together with a read offset. It predicts the read values from its model before applying the operation, then applies the operation to the model and compares every output on the next falling edge. The effect of any operation is seen through the read port of the following step.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  localparam logic [2:0] OP_NONE = 3'd0;
  localparam logic [2:0] OP_PUSH = 3'd1;
  localparam logic [2:0] OP_POP  = 3'd2;
  localparam logic [2:0] OP_WR0  = 3'd3;
  localparam logic [2:0] OP_WRI  = 3'd4;
  localparam logic [2:0] OP_WRIP = 3'd5;

  // operations that name ST(0) and ST(idx) as operands
  function automatic logic op_uses_pair(input logic [2:0] o);
    return (o == OP_WR0) || (o == OP_WRI) || (o == OP_WRIP);
  endfunction

  // operations that release ST(0) on success
  function automatic logic op_pops(input logic [2:0] o);
    return (o == OP_POP) || (o == OP_WRIP);
  endfunction
endpackage

// File: rtl/fpstk_store.sv
module fpstk_store #(
  parameter int DATA_W = 80,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     ra0,
  input  logic [AW-1:0]     ra1,
  output logic [DATA_W-1:0] rd0,
  output logic [DATA_W-1:0] rd1
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  // one write port, two registered read ports (read-before-write)
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd0 <= mem[ra0];
    rd1 <= mem[ra1];
  end
endmodule

// File: rtl/fpstk_ctl.sv
module fpstk_ctl
  import fpstk_pkg::*;
#(
  parameter int DATA_W = 80,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op,
  input  logic [PTR_W-1:0]  idx,
  input  logic [PTR_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] push_data,
  input  logic [DATA_W-1:0] wb_data,
  output logic [PTR_W-1:0]  top_q,
  output logic              we,
  output logic [PTR_W-1:0]  waddr,
  output logic [DATA_W-1:0] wdata,
  output logic [PTR_W-1:0]  ra0,
  output logic [PTR_W-1:0]  ra1,
  output logic              st0_full,
  output logic              sti_full,
  output logic              stk_fault,
  output logic              cond_c1
);
  localparam int DEPTH = 1 << PTR_W;
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [DEPTH-1:0] tags, tag_nxt, set_v, clr_v;
  logic [PTR_W-1:0] ph_i, ph_dn, ph_up;
  logic t0, ti, tdn;
  logic ovf, unf, fault;
  logic push_ok, pop_ok;

  assign ph_i  = top_q + idx;
  assign ph_dn = top_q - ONE;
  assign ph_up = top_q + ONE;
  assign t0    = tags[top_q];
  assign ti    = tags[ph_i];
  assign tdn   = tags[ph_dn];

  always_comb begin
    ovf = 1'b0;
    unf = 1'b0;
    if (op == OP_PUSH)        ovf = tdn;
    else if (op == OP_POP)    unf = !t0;
    else if (op_uses_pair(op)) unf = !t0 || !ti;
  end
  assign fault   = ovf || unf;
  assign push_ok = (op == OP_PUSH) && !ovf;
  assign pop_ok  = op_pops(op) && !unf;

  // write port steering
  always_comb begin
    we    = 1'b0;
    waddr = ph_i;
    wdata = wb_data;
    if (push_ok) begin
      we    = 1'b1;
      waddr = ph_dn;
      wdata = push_data;
    end else if (op_uses_pair(op) && !unf) begin
      we    = 1'b1;
      waddr = (op == OP_WR0) ? top_q : ph_i;
    end
  end

  assign ra0 = top_q;
  assign ra1 = top_q + rd_idx;

  // per-entry tag update
  for (genvar g = 0; g < DEPTH; g++) begin : g_tag
    assign set_v[g]   = push_ok && (ph_dn == PTR_W'(g));
    assign clr_v[g]   = pop_ok  && (top_q == PTR_W'(g));
    assign tag_nxt[g] = set_v[g] || (tags[g] && !clr_v[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tags      <= '0;
      top_q     <= '0;
      stk_fault <= 1'b0;
      cond_c1   <= 1'b0;
      st0_full  <= 1'b0;
      sti_full  <= 1'b0;
    end else begin
      tags      <= tag_nxt;
      stk_fault <= fault;
      st0_full  <= tags[ra0];
      sti_full  <= tags[ra1];
      if (fault)        cond_c1 <= ovf;
      if (push_ok)      top_q   <= ph_dn;
      else if (pop_ok)  top_q   <= ph_up;
    end
  end

  // R4: push onto an occupied register flags overflow, C1 set, pointer frozen
  assert_push_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PUSH && tags[top_q - ONE]) |=> (stk_fault && cond_c1 && top_q == $past(top_q)));

  // R3: successful push moves the pointer down and the new top is full
  assert_push_advance_R3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PUSH && !tags[top_q - ONE]) |=> (top_q == $past(top_q) - ONE && tags[top_q]));

  // R5: successful pop moves the pointer up and empties the old top
  assert_pop_advance_R5: assert property (@(posedge clk) disable iff (rst)
    (op == OP_POP && tags[top_q]) |=> (top_q == $past(top_q) + ONE && $countones(tags) == $countones($past(tags)) - 1));

  // R9: empty ST(0) on a pop-type op is underflow with C1 cleared
  assert_pop_underflow_R9: assert property (@(posedge clk) disable iff (rst)
    (op_pops(op) && !tags[top_q]) |=> (stk_fault && !cond_c1 && top_q == $past(top_q)));

  // R9: any fault leaves the tag vector untouched
  assert_fault_freezes_R9: assert property (@(posedge clk) disable iff (rst)
    stk_fault |-> (tags == $past(tags)));

  // R12: idle codes change nothing and raise nothing
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    (op == OP_NONE || op > OP_WRIP) |=> (!stk_fault && $stable(tags) && $stable(top_q)));
endmodule

// File: rtl/fpstk_regfile.sv
module fpstk_regfile
  import fpstk_pkg::*;
#(
  parameter int DATA_W = 80,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op,
  input  logic [PTR_W-1:0]  idx,
  input  logic [DATA_W-1:0] push_data,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] st0_q,
  output logic [DATA_W-1:0] sti_q,
  output logic              st0_full,
  output logic              sti_full,
  output logic [PTR_W-1:0]  top_q,
  output logic              stk_fault,
  output logic              cond_c1
);
  logic              we;
  logic [PTR_W-1:0]  waddr, ra0, ra1;
  logic [DATA_W-1:0] wdata;

  fpstk_ctl #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_ctl (
    .clk(clk), .rst(rst), .op(op), .idx(idx), .rd_idx(rd_idx),
    .push_data(push_data), .wb_data(wb_data),
    .top_q(top_q), .we(we), .waddr(waddr), .wdata(wdata),
    .ra0(ra0), .ra1(ra1), .st0_full(st0_full), .sti_full(sti_full),
    .stk_fault(stk_fault), .cond_c1(cond_c1)
  );

  fpstk_store #(.DATA_W(DATA_W), .AW(PTR_W)) u_store (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .ra0(ra0), .ra1(ra1), .rd0(st0_q), .rd1(sti_q)
  );

  // R9: a faulting cycle never reaches the array (fault seen one edge later)
  assert_no_write_on_fault_R9: assert property (@(posedge clk) disable iff (rst)
    (we && op == OP_PUSH) |=> !stk_fault);
endmodule

// File: tb/fpstk_regfile_bench.sv
`timescale 1ns/1ps
module fpstk_regfile_bench;
  localparam int DW = 80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] op = 3'd0, idx = 3'd0, rd_idx = 3'd0;
  logic [DW-1:0] push_data = '0, wb_data = '0;
  logic [DW-1:0] st0_q, sti_q;
  logic st0_full, sti_full, stk_fault, cond_c1;
  logic [2:0] top_q;

  always #2.5 clk = ~clk;

  fpstk_regfile #(.DATA_W(DW), .PTR_W(3)) u_fpstk_regfile (
    .clk(clk), .rst(rst), .op(op), .idx(idx), .push_data(push_data),
    .wb_data(wb_data), .rd_idx(rd_idx), .st0_q(st0_q), .sti_q(sti_q),
    .st0_full(st0_full), .sti_full(sti_full), .top_q(top_q),
    .stk_fault(stk_fault), .cond_c1(cond_c1)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  logic [DW-1:0] m_mem [8];
  logic [7:0]    m_tag;
  logic [2:0]    m_top;
  logic          m_c1;

  task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd_data();
    return DW'({$urandom, $urandom, $urandom});
  endfunction

  // model: does the op fault? 1=ovf-type bit returned separately
  function automatic logic m_fault(input logic [2:0] o, input logic [2:0] i, output logic is_ovf);
    logic [2:0] dn = m_top - 3'd1;
    logic [2:0] pi = m_top + i;
    is_ovf = 1'b0;
    case (o)
      3'd1: begin is_ovf = m_tag[dn]; return m_tag[dn]; end
      3'd2: return !m_tag[m_top];
      3'd3, 3'd4, 3'd5: return !m_tag[m_top] || !m_tag[pi];
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input logic [2:0] o, input logic [2:0] i, input logic [2:0] rd,
                      input logic [DW-1:0] pd, input logic [DW-1:0] wd, input string tag);
    logic [2:0] pr = m_top + rd;
    logic e0f = m_tag[m_top], eif = m_tag[pr];
    logic [DW-1:0] e0 = m_mem[m_top], ei = m_mem[pr];
    logic ov, f;
    string rq;
    f = m_fault(o, i, ov);
    if (tag != "") rq = tag;
    else if (f) rq = ov ? "R4" : "R9";
    else case (o)
      3'd1: rq = "R3";
      3'd2: rq = "R5";
      3'd3: rq = "R6";
      3'd4: rq = "R7";
      3'd5: rq = "R8";
      default: rq = "R12";
    endcase
    // model update
    if (f) m_c1 = ov;
    else begin
      case (o)
        3'd1: begin m_top = m_top - 3'd1; m_mem[m_top] = pd; m_tag[m_top] = 1'b1; end
        3'd2: begin m_tag[m_top] = 1'b0; m_top = m_top + 3'd1; end
        3'd3: m_mem[m_top] = wd;
        3'd4: m_mem[3'(m_top + i)] = wd;
        3'd5: begin m_mem[3'(m_top + i)] = wd; m_tag[m_top] = 1'b0; m_top = m_top + 3'd1; end
        default: ;
      endcase
    end
    op = o; idx = i; rd_idx = rd; push_data = pd; wb_data = wd;
    @(posedge clk);
    @(negedge clk);
    chk(rq, "top", DW'(top_q), DW'(m_top));
    chk(rq, "fault", DW'(stk_fault), DW'(f));
    chk(rq, "c1", DW'(cond_c1), DW'(m_c1));
    chk("R2", "st0_full", DW'(st0_full), DW'(e0f));
    chk("R2", "sti_full", DW'(sti_full), DW'(eif));
    if (e0f) chk("R2", "st0_q", st0_q, e0);
    if (eif) chk("R2", "sti_q", sti_q, ei);
  endtask

  // idle step that reads ST(rd)
  task automatic peek(input logic [2:0] rd, input string tag);
    step(3'd0, 3'd0, rd, '0, '0, tag);
  endtask

  initial begin
    void'($urandom(32'd4242));
    m_tag = '0; m_top = '0; m_c1 = 1'b0;
    for (int k = 0; k < 8; k++) m_mem[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "top", DW'(top_q), '0);
    chk("R1", "fault", DW'(stk_fault), '0);
    chk("R1", "c1", DW'(cond_c1), '0);
    chk("R1", "st0_full", DW'(st0_full), '0);
    chk("R1", "sti_full", DW'(sti_full), '0);
    peek(3'd5, "R1");
    // R11: first push wraps top from 0 to 7
    step(3'd1, 3'd0, 3'd0, 80'h3FFF_8000_0000_0000_0001, '0, "R11");
    chk("R11", "top wrap", DW'(top_q), DW'(3'd7));
    // R9: pop-type with empty ST(1)
    step(3'd5, 3'd1, 3'd0, '0, 80'h1, "R9");
    // R10: fault pulse ends, c1 held
    peek(3'd0, "R10");
    // fill remaining seven
    for (int k = 0; k < 7; k++) step(3'd1, 3'd0, 3'd1, rnd_data(), '0, "R3");
    // R4: ninth push overflows
    step(3'd1, 3'd0, 3'd0, rnd_data(), '0, "R4");
    peek(3'd7, "R10");
    // R6: double ST(0) using idx 0
    step(3'd3, 3'd0, 3'd0, 80'h4000_C000_0000_0000_0000, '0, "R6");
    step(3'd3, 3'd0, 3'd0, '0, 80'h4001_C000_0000_0000_0000, "R6");
    peek(3'd0, "R6");
    // R7: write ST(5)
    step(3'd4, 3'd5, 3'd5, '0, 80'hABCD, "R7");
    peek(3'd5, "R7");
    // R8: no-operand add-and-pop form, result at new ST(0)
    step(3'd5, 3'd1, 3'd1, '0, 80'h1234_5678, "R8");
    peek(3'd0, "R8");
    // R8: idx 3 result lands at ST(2)
    step(3'd5, 3'd3, 3'd0, '0, 80'h9999, "R8");
    peek(3'd2, "R8");
    // R12: reserved codes
    step(3'd6, 3'd2, 3'd1, rnd_data(), rnd_data(), "R12");
    step(3'd7, 3'd4, 3'd3, rnd_data(), rnd_data(), "R12");
    // drain to empty, then underflow pop; R11 pop wraps 7->0
    while (m_tag[m_top]) step(3'd2, 3'd0, 3'd1, '0, '0, "R5");
    step(3'd2, 3'd0, 3'd0, '0, '0, "R9");
    // constrained random mix
    for (int k = 0; k < 600; k++) begin
      int r = $urandom_range(0, 9);
      logic [2:0] o;
      if (r < 3) o = 3'd1;
      else if (r < 4) o = 3'd2;
      else if (r < 6) o = 3'd3 + 3'($urandom_range(0, 2));
      else if (r < 9) o = 3'd5 - 3'($urandom_range(0, 1));
      else o = 3'($urandom_range(0, 7));
      step(o, 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), rnd_data(), rnd_data(), "");
    end
    peek(3'd0, "R2");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule